// File: doc/BRIEF.md
# Row-Step Command Sequencer

This block is the controller on the remote sensor card. It receives a single one-cycle command strobe together with a 2-bit function code. Any command that the block accepts first drops the completion flag `rdy_o`, which the host polls. The function code then picks one of four actions:

- run a full horizontal row step with correlated double sampling;
- start the converter on its own;
- clear the auxiliary flip-flop;
- set the auxiliary flip-flop.

A row step drives its outputs in a fixed order:

1. a cell-clear (phase reset) pulse;
2. the reset-level sample gate;
3. the signal-level sample gate, which lasts twice as long as the reset-level gate, with the horizontal shift clock pulsed at its start;
4. a quiet settle interval;
5. the converter-start pulse.

Every width is a parameter counted in clock cycles. Each sample gate holds its value when it falls.

The flag `rdy_o` is raised again by the converter's end-of-conversion input or by the end-of-vertical-transfer input. The auxiliary codes finish at once. They are the host's way to drop `rdy_o` without starting any timing, for example after an externally timed vertical transfer. A row step or a bare conversion keeps the block busy until end-of-conversion. Commands that arrive while it is busy are dropped.

Top module: `rowstep_ctrl`

## Requirements
- R1: While and right after `rst` is high, `rdy_o` is 1, `aux_o` is 0, `busy_o` is 0 and all timing outputs are 0.
- R2: A command is accepted when `cmd_pulse` is high and `busy_o` is low. In the cycle after acceptance `rdy_o` is 0, even if `eoc` or `vshift_done` is high in the accepting cycle.
- R3: Code 2'b00 starts a row step. `cell_clr_o` is high for CLR_W cycles from the cycle after acceptance. `samp_rst_o` is high for the next SRST_W cycles. `samp_sig_o` is high for the next 2*SRST_W cycles.
- R4: `hclk_o` rises together with `samp_sig_o` and stays high for HCLK_W cycles. It is never high without `samp_sig_o`.
- R5: After `samp_sig_o` falls, all timing outputs stay low for SETL_W cycles. Then `conv_go_o` is high for GO_W cycles.
- R6: Code 2'b01 raises `conv_go_o` for GO_W cycles from the cycle after acceptance, with no row-step outputs.
- R7: Code 2'b10 clears `aux_o` and code 2'b11 sets it, both in the cycle after acceptance. Neither code raises `busy_o` or any timing output.
- R8: A high `eoc` or `vshift_done` sets `rdy_o` in the next cycle unless a command is accepted in the same cycle.
- R9: `busy_o` is high from the cycle after a code 2'b00 or 2'b01 is accepted until the cycle after `eoc` is seen once `conv_go_o` has ended. A command strobed while `busy_o` is high changes neither `rdy_o`, `aux_o` nor any timing output.
- R10: At most one of `cell_clr_o`, `samp_rst_o`, `samp_sig_o` and `conv_go_o` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_pulse | input | 1 | One-cycle command strobe |
| cmd_code | input | 2 | Function code sampled with the strobe |
| eoc | input | 1 | Converter end-of-conversion |
| vshift_done | input | 1 | End of vertical transfer |
| rdy_o | output | 1 | Completion flag polled by the host |
| aux_o | output | 1 | Auxiliary flip-flop |
| busy_o | output | 1 | Sequence in progress; commands are dropped |
| cell_clr_o | output | 1 | Phase-reset pulse for the output cell |
| samp_rst_o | output | 1 | Reset-level sample gate |
| samp_sig_o | output | 1 | Signal-level sample gate |
| hclk_o | output | 1 | Horizontal shift pulse |
| conv_go_o | output | 1 | Converter start |

## Verification
The bound checker watches, on every cycle:

- that the four exclusive timing outputs are never high together;
- that the shift clock only appears inside the signal gate and is high when that gate rises;
- that the reset-level gate always follows a cell-clear;
- that the settle gap directly follows the signal gate;
- how `rdy_o` and `aux_o` respond to accepted, dropped and simultaneous commands and completion inputs.

The exact widths of every pulse and the phase offsets between them can only be shown by the bench's scenarios. The same holds for dropped commands at several points inside a busy sequence, for back-to-back commands right after a completion, and for a stray end-of-conversion outside a sequence.

// File: rtl/rowstep_pkg.sv
package rowstep_pkg;

  typedef enum logic [1:0] {
    FN_ROW    = 2'b00,
    FN_CONV   = 2'b01,
    FN_AUXCLR = 2'b10,
    FN_AUXSET = 2'b11
  } fn_t;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_CLR,
    SQ_SRST,
    SQ_SSIG,
    SQ_SETL,
    SQ_GO,
    SQ_WAIT
  } sq_t;

  typedef struct packed {
    logic clr;
    logic srst;
    logic ssig;
    logic hclk;
    logic go;
  } gates_t;

endpackage

// File: rtl/rowstep_cmd_gate.sv
module rowstep_cmd_gate
  import rowstep_pkg::*;
(
  input  logic       cmd_pulse,
  input  logic [1:0] cmd_code,
  input  logic       busy,
  output logic       accept,
  output logic       go_row,
  output logic       go_conv,
  output logic       aux_set,
  output logic       aux_clr
);

  fn_t fn;

  always_comb begin
    fn      = fn_t'(cmd_code);
    accept  = cmd_pulse && !busy;
    go_row  = accept && (fn == FN_ROW);
    go_conv = accept && (fn == FN_CONV);
    aux_clr = accept && (fn == FN_AUXCLR);
    aux_set = accept && (fn == FN_AUXSET);
  end

endmodule

// File: rtl/rowstep_flags.sv
module rowstep_flags (
  input  logic clk,
  input  logic rst,
  input  logic accept,
  input  logic aux_set,
  input  logic aux_clr,
  input  logic eoc,
  input  logic vshift_done,
  output logic rdy,
  output logic aux
);

  always_ff @(posedge clk) begin
    if (rst) begin
      rdy <= 1'b1;
      aux <= 1'b0;
    end else begin
      if (accept)
        rdy <= 1'b0;
      else if (eoc || vshift_done)
        rdy <= 1'b1;

      if (aux_set)
        aux <= 1'b1;
      else if (aux_clr)
        aux <= 1'b0;
    end
  end

endmodule

// File: rtl/rowstep_seq.sv
module rowstep_seq
  import rowstep_pkg::*;
#(
  parameter int CLR_W  = 2,
  parameter int SRST_W = 3,
  parameter int HCLK_W = 2,
  parameter int SETL_W = 4,
  parameter int GO_W   = 1
) (
  input  logic   clk,
  input  logic   rst,
  input  logic   go_row,
  input  logic   go_conv,
  input  logic   eoc,
  output gates_t gates,
  output logic   busy
);

  localparam int SSIG_W = 2 * SRST_W;
  localparam int M1     = (CLR_W > SRST_W) ? CLR_W : SRST_W;
  localparam int M2     = (M1 > SSIG_W) ? M1 : SSIG_W;
  localparam int M3     = (M2 > SETL_W) ? M2 : SETL_W;
  localparam int MAXW   = (M3 > GO_W) ? M3 : GO_W;
  localparam int CW     = $clog2(MAXW + 1);

  localparam logic [CW-1:0] CLR_LD  = CW'(CLR_W - 1);
  localparam logic [CW-1:0] SRST_LD = CW'(SRST_W - 1);
  localparam logic [CW-1:0] SSIG_LD = CW'(SSIG_W - 1);
  localparam logic [CW-1:0] SETL_LD = CW'(SETL_W - 1);
  localparam logic [CW-1:0] GO_LD   = CW'(GO_W - 1);

  sq_t           st_q, st_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic          last;
  gates_t        gates_n;
  logic          hclk_n;

  assign last = (cnt_q == '0);

  always_comb begin
    st_n  = st_q;
    cnt_n = last ? cnt_q : (cnt_q - CW'(1));
    unique case (st_q)
      SQ_IDLE: begin
        if (go_row) begin
          st_n  = SQ_CLR;
          cnt_n = CLR_LD;
        end else if (go_conv) begin
          st_n  = SQ_GO;
          cnt_n = GO_LD;
        end
      end
      SQ_CLR: if (last) begin
        st_n  = SQ_SRST;
        cnt_n = SRST_LD;
      end
      SQ_SRST: if (last) begin
        st_n  = SQ_SSIG;
        cnt_n = SSIG_LD;
      end
      SQ_SSIG: if (last) begin
        st_n  = SQ_SETL;
        cnt_n = SETL_LD;
      end
      SQ_SETL: if (last) begin
        st_n  = SQ_GO;
        cnt_n = GO_LD;
      end
      SQ_GO: if (last) begin
        st_n  = SQ_WAIT;
        cnt_n = '0;
      end
      SQ_WAIT: if (eoc) st_n = SQ_IDLE;
      default: st_n = SQ_IDLE;
    endcase
  end

  // The shift clock covers the first HCLK_W cycles of the signal gate;
  // a width that fills the whole gate needs no count compare.
  generate
    if (HCLK_W >= SSIG_W) begin : g_hclk_full
      assign hclk_n = (st_n == SQ_SSIG);
    end else begin : g_hclk_part
      localparam logic [CW-1:0] HCLK_TH = CW'(SSIG_W - HCLK_W);
      assign hclk_n = (st_n == SQ_SSIG) && (cnt_n >= HCLK_TH);
    end
  endgenerate

  always_comb begin
    gates_n.clr  = (st_n == SQ_CLR);
    gates_n.srst = (st_n == SQ_SRST);
    gates_n.ssig = (st_n == SQ_SSIG);
    gates_n.hclk = hclk_n;
    gates_n.go   = (st_n == SQ_GO);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= SQ_IDLE;
      cnt_q <= '0;
      gates <= '0;
      busy  <= 1'b0;
    end else begin
      st_q  <= st_n;
      cnt_q <= cnt_n;
      gates <= gates_n;
      busy  <= (st_n != SQ_IDLE);
    end
  end

endmodule

// File: rtl/rowstep_ctrl.sv
module rowstep_ctrl
  import rowstep_pkg::*;
#(
  parameter int CLR_W  = 2,
  parameter int SRST_W = 3,
  parameter int HCLK_W = 2,
  parameter int SETL_W = 4,
  parameter int GO_W   = 1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cmd_pulse,
  input  logic [1:0] cmd_code,
  input  logic       eoc,
  input  logic       vshift_done,
  output logic       rdy_o,
  output logic       aux_o,
  output logic       busy_o,
  output logic       cell_clr_o,
  output logic       samp_rst_o,
  output logic       samp_sig_o,
  output logic       hclk_o,
  output logic       conv_go_o
);

  logic   accept, go_row, go_conv, aux_set, aux_clr;
  gates_t gates;

  rowstep_cmd_gate u_gate (
    .cmd_pulse (cmd_pulse),
    .cmd_code  (cmd_code),
    .busy      (busy_o),
    .accept    (accept),
    .go_row    (go_row),
    .go_conv   (go_conv),
    .aux_set   (aux_set),
    .aux_clr   (aux_clr)
  );

  rowstep_seq #(
    .CLR_W  (CLR_W),
    .SRST_W (SRST_W),
    .HCLK_W (HCLK_W),
    .SETL_W (SETL_W),
    .GO_W   (GO_W)
  ) u_seq (
    .clk     (clk),
    .rst     (rst),
    .go_row  (go_row),
    .go_conv (go_conv),
    .eoc     (eoc),
    .gates   (gates),
    .busy    (busy_o)
  );

  rowstep_flags u_flags (
    .clk         (clk),
    .rst         (rst),
    .accept      (accept),
    .aux_set     (aux_set),
    .aux_clr     (aux_clr),
    .eoc         (eoc),
    .vshift_done (vshift_done),
    .rdy         (rdy_o),
    .aux         (aux_o)
  );

  assign cell_clr_o = gates.clr;
  assign samp_rst_o = gates.srst;
  assign samp_sig_o = gates.ssig;
  assign hclk_o     = gates.hclk;
  assign conv_go_o  = gates.go;

endmodule

// File: rtl/rowstep_ctrl_chk.sv
module rowstep_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic       cmd_pulse,
  input logic [1:0] cmd_code,
  input logic       eoc,
  input logic       vshift_done,
  input logic       rdy_o,
  input logic       aux_o,
  input logic       busy_o,
  input logic       cell_clr_o,
  input logic       samp_rst_o,
  input logic       samp_sig_o,
  input logic       hclk_o,
  input logic       conv_go_o
);

  logic acc;
  assign acc = cmd_pulse && !busy_o;

  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (rdy_o && !aux_o && !busy_o && !cell_clr_o && !conv_go_o));

  assert_accept_clears_R2: assert property (@(posedge clk) disable iff (rst)
    acc |=> !rdy_o);

  assert_srst_after_clr_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(samp_rst_o) |-> $past(cell_clr_o));

  assert_hclk_in_sig_R4: assert property (@(posedge clk) disable iff (rst)
    hclk_o |-> samp_sig_o);

  assert_hclk_at_sig_start_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(samp_sig_o) |-> hclk_o);

  assert_settle_gap_R5: assert property (@(posedge clk) disable iff (rst)
    $fell(samp_sig_o) |-> !conv_go_o);

  assert_bare_conv_R6: assert property (@(posedge clk) disable iff (rst)
    (acc && cmd_code == 2'b01) |=> (conv_go_o && !cell_clr_o && busy_o));

  assert_aux_set_R7: assert property (@(posedge clk) disable iff (rst)
    (acc && cmd_code == 2'b11) |=> (aux_o && !busy_o));

  assert_aux_clr_R7: assert property (@(posedge clk) disable iff (rst)
    (acc && cmd_code == 2'b10) |=> (!aux_o && !busy_o));

  assert_done_sets_R8: assert property (@(posedge clk) disable iff (rst)
    ((eoc || vshift_done) && !acc) |=> rdy_o);

  assert_busy_aux_R9: assert property (@(posedge clk) disable iff (rst)
    (cmd_pulse && busy_o) |=> $stable(aux_o));

  assert_busy_rdy_R9: assert property (@(posedge clk) disable iff (rst)
    (cmd_pulse && busy_o && !eoc && !vshift_done) |=> $stable(rdy_o));

  assert_exclusive_R10: assert property (@(posedge clk) disable iff (rst)
    $onehot0({cell_clr_o, samp_rst_o, samp_sig_o, conv_go_o}));

endmodule

bind rowstep_ctrl rowstep_ctrl_chk u_chk (.*);

// File: tb/sim_rowstep_ctrl.sv
module sim_rowstep_ctrl;

  localparam int CLR_W  = 2;
  localparam int SRST_W = 3;
  localparam int HCLK_W = 2;
  localparam int SETL_W = 4;
  localparam int GO_W   = 1;

  // event kinds: 2*bit + (fall ? 1 : 0); bits 0 clr,1 srst,2 ssig,3 hclk,4 go,5 rdy,6 aux
  localparam int K_CLR_R = 0,  K_CLR_F = 1,  K_SRST_R = 2, K_SRST_F = 3;
  localparam int K_SSIG_R = 4, K_SSIG_F = 5, K_HCLK_R = 6, K_HCLK_F = 7;
  localparam int K_GO_R = 8,   K_GO_F = 9,   K_RDY_R = 10, K_RDY_F = 11;
  localparam int K_AUX_R = 12, K_AUX_F = 13;

  typedef struct {
    int    kind;
    int    cyc;
    string req;
  } ev_t;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cmd_pulse = 1'b0;
  logic [1:0] cmd_code = 2'b00;
  logic       eoc = 1'b0;
  logic       vshift_done = 1'b0;
  logic       rdy_o, aux_o, busy_o, cell_clr_o, samp_rst_o, samp_sig_o, hclk_o, conv_go_o;

  int  cyc = 0;
  int  n_checks = 0;
  int  n_fail = 0;
  int  excl_bad = 0;
  bit  mon_on = 1'b0;
  bit  done = 1'b0;
  bit  m_ready = 1'b1;
  bit  m_aux = 1'b0;
  bit  m_busy = 1'b0;
  ev_t exp_q[$];
  logic [6:0] cur, prv;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  rowstep_ctrl #(
    .CLR_W (CLR_W), .SRST_W (SRST_W), .HCLK_W (HCLK_W), .SETL_W (SETL_W), .GO_W (GO_W)
  ) u0 (
    .clk (clk), .rst (rst), .cmd_pulse (cmd_pulse), .cmd_code (cmd_code),
    .eoc (eoc), .vshift_done (vshift_done), .rdy_o (rdy_o), .aux_o (aux_o),
    .busy_o (busy_o), .cell_clr_o (cell_clr_o), .samp_rst_o (samp_rst_o),
    .samp_sig_o (samp_sig_o), .hclk_o (hclk_o), .conv_go_o (conv_go_o)
  );

  assign cur = {aux_o, rdy_o, conv_go_o, hclk_o, samp_sig_o, samp_rst_o, cell_clr_o};

  function automatic string kname(input int k);
    case (k)
      K_CLR_R: return "cell_clr rise";   K_CLR_F: return "cell_clr fall";
      K_SRST_R: return "samp_rst rise";  K_SRST_F: return "samp_rst fall";
      K_SSIG_R: return "samp_sig rise";  K_SSIG_F: return "samp_sig fall";
      K_HCLK_R: return "hclk rise";      K_HCLK_F: return "hclk fall";
      K_GO_R: return "conv_go rise";     K_GO_F: return "conv_go fall";
      K_RDY_R: return "rdy rise";        K_RDY_F: return "rdy fall";
      K_AUX_R: return "aux rise";        default: return "aux fall";
    endcase
  endfunction

  task automatic push(input int kind, input int c, input string req);
    ev_t e;
    e.kind = kind;
    e.cyc  = c;
    e.req  = req;
    exp_q.push_back(e);
  endtask

  // monitor side: pop the matching expectation or flag an unexpected change
  task automatic match(input int kind, input int c);
    bit found = 1'b0;
    for (int i = 0; i < exp_q.size(); i++) begin
      if (!found && exp_q[i].kind == kind && exp_q[i].cyc == c) begin
        exp_q.delete(i);
        found = 1'b1;
      end
    end
    n_checks++;
    if (!found) begin
      n_fail++;
      $display("FAIL R9 unexpected %s: actual cycle %0d, expected no change", kname(kind), c);
    end
  endtask

  always @(negedge clk) begin
    if (mon_on) begin
      for (int k = 0; k < 7; k++) begin
        if (cur[k] != prv[k]) match(2 * k + (cur[k] ? 0 : 1), cyc);
      end
      if ($countones({cur[4], cur[2], cur[1], cur[0]}) > 1 || (cur[3] && !cur[2]))
        excl_bad++;
    end
    prv = cur;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d, expected %0d", req, what, act, exp);
    end
  endtask

  task automatic expect_empty();
    @(negedge clk);
    #1;
    if (exp_q.size() == 0) begin
      n_checks++;
    end else begin
      foreach (exp_q[i]) begin
        n_checks++;
        n_fail++;
        $display("FAIL %s missing %s: actual none, expected cycle %0d",
                 exp_q[i].req, kname(exp_q[i].kind), exp_q[i].cyc);
      end
      exp_q.delete();
    end
  endtask

  // driver: strobe one command, optionally with vshift_done, and queue the expected results
  task automatic issue(input logic [1:0] code, input bit with_vs);
    int a;
    int t;
    @(negedge clk);
    cmd_pulse   = 1'b1;
    cmd_code    = code;
    vshift_done = with_vs;
    @(posedge clk);
    #1;
    a = cyc;
    cmd_pulse   = 1'b0;
    vshift_done = 1'b0;
    if (!m_busy) begin
      if (m_ready) push(K_RDY_F, a, "R2");
      m_ready = 1'b0;
      case (code)
        2'b00: begin
          t = a;
          push(K_CLR_R, t, "R3");
          t += CLR_W;
          push(K_CLR_F, t, "R3");
          push(K_SRST_R, t, "R3");
          t += SRST_W;
          push(K_SRST_F, t, "R3");
          push(K_SSIG_R, t, "R3");
          push(K_HCLK_R, t, "R4");
          push(K_HCLK_F, t + HCLK_W, "R4");
          t += 2 * SRST_W;
          push(K_SSIG_F, t, "R3");
          t += SETL_W;
          push(K_GO_R, t, "R5");
          push(K_GO_F, t + GO_W, "R5");
          m_busy = 1'b1;
        end
        2'b01: begin
          push(K_GO_R, a, "R6");
          push(K_GO_F, a + GO_W, "R6");
          m_busy = 1'b1;
        end
        2'b10: begin
          if (m_aux) push(K_AUX_F, a, "R7");
          m_aux = 1'b0;
        end
        default: begin
          if (!m_aux) push(K_AUX_R, a, "R7");
          m_aux = 1'b1;
        end
      endcase
    end else if (with_vs && !m_ready) begin
      push(K_RDY_R, a, "R8");
      m_ready = 1'b1;
    end
  endtask

  task automatic pulse_eoc();
    int a;
    @(negedge clk);
    eoc = 1'b1;
    @(posedge clk);
    #1;
    a = cyc;
    eoc = 1'b0;
    if (!m_ready) push(K_RDY_R, a, "R8");
    m_ready = 1'b1;
    m_busy  = 1'b0;
  endtask

  task automatic pulse_vs();
    int a;
    @(negedge clk);
    vshift_done = 1'b1;
    @(posedge clk);
    #1;
    a = cyc;
    vshift_done = 1'b0;
    if (!m_ready) push(K_RDY_R, a, "R8");
    m_ready = 1'b1;
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual hung run, expected completion");
      report();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    check(rdy_o === 1'b1, "R1", "rdy_o in reset", rdy_o, 1);
    check(aux_o === 1'b0, "R1", "aux_o in reset", aux_o, 0);
    check(busy_o === 1'b0, "R1", "busy_o in reset", busy_o, 0);
    check({cell_clr_o, samp_rst_o, samp_sig_o, hclk_o, conv_go_o} === 5'b0, "R1",
          "timing outputs in reset", {cell_clr_o, samp_rst_o, samp_sig_o, hclk_o, conv_go_o}, 0);
    rst = 1'b0;
    @(posedge clk);
    #1;
    mon_on = 1'b1;

    // R3 R4 R5: full row step, with commands dropped mid-sequence and while waiting (R9)
    issue(2'b00, 1'b0);
    issue(2'b00, 1'b0);
    issue(2'b11, 1'b0);
    repeat (16) @(posedge clk);
    @(negedge clk);
    check(busy_o === 1'b1, "R9", "busy_o while waiting for eoc", busy_o, 1);
    issue(2'b01, 1'b0);
    pulse_eoc();
    @(negedge clk);
    check(busy_o === 1'b0, "R9", "busy_o after eoc", busy_o, 0);
    check(aux_o === 1'b0, "R9", "aux_o after dropped set command", aux_o, 0);
    expect_empty();

    // R6: bare conversion issued right after a completion
    issue(2'b01, 1'b0);
    repeat (3) @(posedge clk);
    pulse_eoc();
    expect_empty();

    // R7 + R8: auxiliary set, then vertical-transfer completion
    issue(2'b11, 1'b0);
    @(negedge clk);
    check(busy_o === 1'b0, "R7", "busy_o after aux set", busy_o, 0);
    pulse_vs();
    expect_empty();

    // R7 + R8: auxiliary clear, then a stray end-of-conversion
    issue(2'b10, 1'b0);
    pulse_eoc();
    expect_empty();

    // R2: an accepted command wins over a simultaneous completion
    issue(2'b11, 1'b1);
    @(negedge clk);
    check(rdy_o === 1'b0, "R2", "rdy_o after command with vshift_done", rdy_o, 0);
    pulse_eoc();
    expect_empty();

    // second row step, then R10 exclusivity over the whole run
    issue(2'b00, 1'b0);
    repeat (20) @(posedge clk);
    pulse_eoc();
    expect_empty();
    check(excl_bad == 0, "R10", "cycles with overlapping timing outputs", excl_bad, 0);

    done = 1'b1;
    report();
  end

endmodule